// File: doc/BRIEF.md
# Multi-Line Atomic Event Monitor

This block follows one atomic region for a single hardware thread while that region runs over many instructions. Locked loads and locked prefetches enrol cache lines into a small participation set. Plain stores issued while the region is open are held back in a local write buffer. A snoop port reports memory actions by other agents, and each snoop carries the requester's priority. When an intruder with a strictly higher priority than the region's owner touches an enrolled line, the region is killed. Software can read that state at any time through the interference flag, and it uses the flag to choose between the update path and the failure path.

The locked store closes the region. The cycle after the locked store, the block raises a one-cycle done pulse and a pass bit. On success it presents every buffered store, plus the closing store, on a wide commit port in that same single cycle. The memory model beside the block applies them all at once. On failure the commit enables stay low, so no buffered store becomes visible. In both cases the participation set, the buffer and the flag are empty again by that same cycle.

Top module: `mline_atomic_mon`

## Requirements
- R1: At most 8 distinct lines (64-byte granularity, line = address bits 31:6) can be enrolled. Enrolling a ninth distinct line sets `evt_intf` on the next cycle, and the region then fails.
- R2: Enrolling a line that is already enrolled uses no new slot. After 8 distinct lines plus repeats, `evt_intf` stays 0.
- R3: A plain store (`req_lock`=0, `req_wr`=1) during an open region, to a line that is not enrolled, sets `evt_intf` on the next cycle.
- R4: A snoop that hits an enrolled line with `snp_prio` strictly greater than the owner's priority sets `evt_intf` on the next cycle.
- R5: A snoop with priority less than or equal to the owner's priority, or one that hits no enrolled line, leaves `evt_intf` at 0.
- R6: `evt_intf` is 0 after reset and while no region is open. Once set, it stays 1 until the locked store.
- R7: A locked store (`req_lock`=1, `req_wr`=1) to an enrolled line, with no interference, gives `done`=1 and `pass`=1 on the next cycle, for exactly one cycle. In that cycle the commit port shows all buffered stores in issue order in slots 0, 1, 2, …, with the closing store in the next slot. `cm_en` has the low n bits set, and slot i sits at bits [i*W +: W] of each flat bus.
- R8: A failing region gives `done`=1, `pass`=0, and `cm_en`=0.
- R9: By the `done` cycle, `evt_active` and `evt_intf` are 0 and the line set and buffer are empty. A following region can again enrol 8 fresh lines and commit.
- R10: A snoop from a higher-priority agent that hits an enrolled line in the same cycle as the locked store aborts the region.
- R11: The request encoding is {`req_lock`,`req_wr`}: 10 enrols, 01 is a buffered plain store, 11 closes, and 00 is ignored. Plain loads and plain stores while no region is open have no effect. The owner's priority is taken from the request that opens the region.
- R12: The write buffer holds 8 entries, and the closing store needs one of them. A closing store with 8 plain stores already buffered fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Memory request from the owning thread is valid |
| req_lock | input | 1 | Locked-operation flag carried on the request |
| req_wr | input | 1 | Request is a store |
| req_addr | input | 32 | Byte address of the request |
| req_data | input | 32 | Store data |
| req_mask | input | 4 | Store byte enables |
| req_prio | input | 3 | Priority carried by the request |
| snp_valid | input | 1 | Memory action by another agent is valid |
| snp_line | input | 26 | Line address of that action (address bits 31:6) |
| snp_prio | input | 3 | Priority of the other agent |
| evt_active | output | 1 | An atomic region is open |
| evt_intf | output | 1 | Interference flag; the region has been killed |
| done | output | 1 | One-cycle pulse after the locked store |
| pass | output | 1 | Region outcome, valid with done |
| cm_en | output | 8 | Per-slot commit enables |
| cm_addr | output | 256 | Commit addresses, slot i at [i*32 +: 32] |
| cm_data | output | 256 | Commit data, slot i at [i*32 +: 32] |
| cm_mask | output | 32 | Commit byte enables, slot i at [i*4 +: 4] |

## Verification
The closing locked store and a killing snoop can land in the same cycle, and the block must let the snoop win. The bench drives a higher-priority snoop on an enrolled line together with the locked store, and expects done with pass low and no commit enable. As a control, it repeats the same cycle with an equal-priority snoop and expects a clean commit of the closing store.

// File: rtl/mlam_pkg.sv
package mlam_pkg;
    localparam int MLAM_LINES = 8;   // participation set depth
    localparam int MLAM_WBUF  = 8;   // held stores, closing store included
    localparam int MLAM_AW    = 32;
    localparam int MLAM_DW    = 32;
    localparam int MLAM_PW    = 3;
    localparam int MLAM_LOFF  = 6;   // 64-byte lines

    // request kind is {lock, wr}
    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_STORE  = 2'b01,
        OP_ENROLL = 2'b10,
        OP_FINAL  = 2'b11
    } op_e;
endpackage

// File: rtl/mlam_line_match.sv
module mlam_line_match #(
    parameter int N = 8,
    parameter int W = 26
) (
    input  logic [N-1:0]        valid,
    input  logic [N-1:0][W-1:0] tags,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/mlam_first_free.sv
module mlam_first_free #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  busy,
    output logic [IW-1:0] idx,
    output logic          full
);
    always_comb begin
        idx  = '0;
        full = &busy;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/mline_atomic_mon.sv
module mline_atomic_mon
    import mlam_pkg::*;
#(
    parameter int LINES    = MLAM_LINES,
    parameter int WBUF     = MLAM_WBUF,
    parameter int AW       = MLAM_AW,
    parameter int DW       = MLAM_DW,
    parameter int PW       = MLAM_PW,
    parameter int LINE_OFF = MLAM_LOFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_lock,
    input  logic                 req_wr,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_data,
    input  logic [DW/8-1:0]      req_mask,
    input  logic [PW-1:0]        req_prio,
    input  logic                 snp_valid,
    input  logic [AW-LINE_OFF-1:0] snp_line,
    input  logic [PW-1:0]        snp_prio,
    output logic                 evt_active,
    output logic                 evt_intf,
    output logic                 done,
    output logic                 pass,
    output logic [WBUF-1:0]      cm_en,
    output logic [WBUF*AW-1:0]   cm_addr,
    output logic [WBUF*DW-1:0]   cm_data,
    output logic [WBUF*DW/8-1:0] cm_mask
);
    localparam int LW  = AW - LINE_OFF;
    localparam int MW  = DW / 8;
    localparam int LIW = $clog2(LINES);
    localparam int WIW = $clog2(WBUF);

    typedef struct packed {
        logic                       active;
        logic                       intf;
        logic [PW-1:0]              owner;
        logic [LINES-1:0]           lv;
        logic [LINES-1:0][LW-1:0]   la;
        logic [WBUF-1:0]            wv;
        logic [WBUF-1:0][AW-1:0]    wa;
        logic [WBUF-1:0][DW-1:0]    wd;
        logic [WBUF-1:0][MW-1:0]    wm;
        logic                       done;
        logic                       pass;
        logic [WBUF-1:0]            cen;
        logic [WBUF-1:0][AW-1:0]    ca;
        logic [WBUF-1:0][DW-1:0]    cd;
        logic [WBUF-1:0][MW-1:0]    cm;
    } st_t;

    st_t st_d, st_q;

    logic [LW-1:0]    req_line;
    logic [LINES-1:0] req_hit, snp_hit;
    logic             req_any, snp_kill, line_full, buf_full, fin_ok;
    logic [LIW-1:0]   line_idx;
    logic [WIW-1:0]   buf_idx;
    op_e              op;

    assign req_line = req_addr[AW-1:LINE_OFF];
    assign op       = req_valid ? op_e'({req_lock, req_wr}) : OP_NONE;

    mlam_line_match #(.N(LINES), .W(LW)) u_req_match (
        .valid(st_q.lv), .tags(st_q.la), .key(req_line), .hit(req_hit)
    );
    mlam_line_match #(.N(LINES), .W(LW)) u_snp_match (
        .valid(st_q.lv), .tags(st_q.la), .key(snp_line), .hit(snp_hit)
    );
    mlam_first_free #(.N(LINES)) u_line_free (
        .busy(st_q.lv), .idx(line_idx), .full(line_full)
    );
    mlam_first_free #(.N(WBUF)) u_buf_free (
        .busy(st_q.wv), .idx(buf_idx), .full(buf_full)
    );

    assign req_any  = |req_hit;
    // an intruder must strictly outrank the owner to kill the region
    assign snp_kill = st_q.active && snp_valid && (|snp_hit) && (snp_prio > st_q.owner);
    assign fin_ok   = st_q.active && !st_q.intf && !snp_kill && req_any && !buf_full;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.pass = 1'b0;
        st_d.cen  = '0;
        if (snp_kill) st_d.intf = 1'b1;
        case (op)
            OP_ENROLL: begin
                if (!st_q.active) begin
                    st_d.active = 1'b1;
                    st_d.owner  = req_prio;
                end
                if (!req_any) begin
                    if (line_full) begin
                        st_d.intf = 1'b1;
                    end else begin
                        st_d.lv[line_idx] = 1'b1;
                        st_d.la[line_idx] = req_line;
                    end
                end
            end
            OP_STORE: begin
                if (st_q.active) begin
                    if (!req_any || buf_full) begin
                        st_d.intf = 1'b1;
                    end else begin
                        st_d.wv[buf_idx] = 1'b1;
                        st_d.wa[buf_idx] = req_addr;
                        st_d.wd[buf_idx] = req_data;
                        st_d.wm[buf_idx] = req_mask;
                    end
                end
            end
            OP_FINAL: begin
                st_d.done = 1'b1;
                st_d.pass = fin_ok;
                st_d.ca   = st_q.wa;
                st_d.cd   = st_q.wd;
                st_d.cm   = st_q.wm;
                if (!buf_full) begin
                    st_d.ca[buf_idx] = req_addr;
                    st_d.cd[buf_idx] = req_data;
                    st_d.cm[buf_idx] = req_mask;
                end
                st_d.cen    = fin_ok ? (st_q.wv | (WBUF'(1) << buf_idx)) : '0;
                st_d.active = 1'b0;
                st_d.intf   = 1'b0;
                st_d.owner  = '0;
                st_d.lv     = '0;
                st_d.wv     = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_active = st_q.active;
    assign evt_intf   = st_q.intf;
    assign done       = st_q.done;
    assign pass       = st_q.pass;
    assign cm_en      = st_q.cen;
    assign cm_addr    = st_q.ca;
    assign cm_data    = st_q.cd;
    assign cm_mask    = st_q.cm;

    // R1: a ninth distinct line raises the flag
    p_line_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ENROLL && st_q.active && !req_any && line_full) |=> evt_intf);
    // R2: no line is held twice
    p_unique_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_hit));
    // R4: an outranking snoop hit raises the flag
    p_snoop_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_kill && op != OP_FINAL) |=> evt_intf);
    // R6: the flag holds until the region closes
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_intf && op != OP_FINAL) |=> evt_intf);
    // R8: a failed region commits nothing
    p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (cm_en == '0));
    // R7: a passing region always commits at least the closing store
    p_pass_commits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (cm_en != '0));
    // R9: no open region means clean state
    p_idle_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_active |-> (!evt_intf && st_q.lv == '0 && st_q.wv == '0));
    // R10: a same-cycle killing snoop beats the closing store
    p_abort_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FINAL && snp_kill) |=> (done && !pass));
endmodule

// File: tb/mline_atomic_mon_bench.sv
module mline_atomic_mon_bench;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_lock = 1'b0, req_wr = 1'b0;
    logic [31:0] req_addr = '0, req_data = '0;
    logic [3:0]  req_mask = '0;
    logic [2:0]  req_prio = '0;
    logic        snp_valid = 1'b0;
    logic [25:0] snp_line = '0;
    logic [2:0]  snp_prio = '0;
    logic        evt_active, evt_intf, done, pass;
    logic [NB-1:0]    cm_en;
    logic [NB*32-1:0] cm_addr, cm_data;
    logic [NB*4-1:0]  cm_mask;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic                 ok;
        logic [NB-1:0]        en;
        logic [NB-1:0][31:0]  a;
        logic [NB-1:0][31:0]  d;
        logic [NB-1:0][3:0]   m;
    } exp_t;

    exp_t sb[$];
    exp_t got;
    logic [NB-1:0][31:0] ma, md;
    logic [NB-1:0][3:0]  mm;
    int mn = 0;

    always #4 clk = ~clk;   // 125 MHz

    mline_atomic_mon u_mline_atomic_mon (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_lock(req_lock), .req_wr(req_wr),
        .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask), .req_prio(req_prio),
        .snp_valid(snp_valid), .snp_line(snp_line), .snp_prio(snp_prio),
        .evt_active(evt_active), .evt_intf(evt_intf), .done(done), .pass(pass),
        .cm_en(cm_en), .cm_addr(cm_addr), .cm_data(cm_data), .cm_mask(cm_mask)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one request cycle, optional snoop in the same cycle; returns at the next falling edge
    task automatic cyc(input bit v, input bit lk, input bit wr, input logic [31:0] a,
                       input logic [31:0] d, input logic [3:0] m, input logic [2:0] p,
                       input bit sv, input logic [31:0] sa, input logic [2:0] sp);
        req_valid = v; req_lock = lk; req_wr = wr; req_addr = a;
        req_data = d; req_mask = m; req_prio = p;
        snp_valid = sv; snp_line = sa[31:6]; snp_prio = sp;
        @(negedge clk);
        req_valid = 1'b0; req_lock = 1'b0; req_wr = 1'b0; snp_valid = 1'b0;
    endtask

    task automatic enroll(input logic [31:0] a, input logic [2:0] p);
        cyc(1, 1, 0, a, 0, 0, p, 0, 0, 0);
    endtask

    task automatic snoop(input logic [31:0] a, input logic [2:0] p);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, a, p);
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] m);
        if (mn < NB) begin ma[mn] = a; md[mn] = d; mm[mn] = m; mn++; end
        cyc(1, 0, 1, a, d, m, 0, 0, 0, 0);
    endtask

    // driver: pushes the expected outcome, then issues the closing store
    task automatic close(input logic [31:0] a, input logic [31:0] d, input logic [3:0] m,
                         input bit exp_ok, input bit sv, input logic [31:0] sa, input logic [2:0] sp);
        exp_t e;
        e = '0;
        if (mn < NB) begin ma[mn] = a; md[mn] = d; mm[mn] = m; mn++; end
        e.ok = exp_ok;
        if (exp_ok) begin
            for (int i = 0; i < NB; i++) begin
                if (i < mn) begin
                    e.en[i] = 1'b1; e.a[i] = ma[i]; e.d[i] = md[i]; e.m[i] = mm[i];
                end
            end
        end
        sb.push_back(e);
        mn = 0;
        cyc(1, 1, 1, a, d, m, 0, sv, sa, sp);
    endtask

    // monitor: compares every done pulse against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk("R7 unexpected done", 1, 0);
            end else begin
                got = sb.pop_front();
                chk(got.ok ? "R7 pass bit" : "R8 pass bit", {63'd0, pass}, {63'd0, got.ok});
                chk(got.ok ? "R7 commit enables" : "R8 commit enables", {56'd0, cm_en}, {56'd0, got.en});
                for (int i = 0; i < NB; i++) begin
                    if (got.en[i]) begin
                        chk("R7 slot addr", {32'd0, cm_addr[i*32 +: 32]}, {32'd0, got.a[i]});
                        chk("R7 slot data", {32'd0, cm_data[i*32 +: 32]}, {32'd0, got.d[i]});
                        chk("R7 slot mask", {60'd0, cm_mask[i*4 +: 4]}, {60'd0, got.m[i]});
                    end
                end
                chk("R9 cleared at done", {62'd0, evt_active, evt_intf}, 64'd0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset state", {61'd0, evt_active, evt_intf, done}, 64'd0);

        // R11: idle plain traffic is ignored
        cyc(1, 0, 1, 32'hE000, 32'h55, 4'hF, 7, 0, 0, 0);
        cyc(1, 0, 0, 32'hE000, 0, 0, 7, 0, 0, 0);
        chk("R11 idle traffic ignored", {62'd0, evt_active, done}, 64'd0);

        // clean region with repeats and harmless snoops (R2, R5, R7)
        enroll(32'h1000, 2);
        enroll(32'h1040, 2);
        enroll(32'h2000, 2);
        enroll(32'h1010, 2);
        chk("R11 region opened", {63'd0, evt_active}, 64'd1);
        store(32'h1004, 32'hA1A1_0001, 4'hF);
        store(32'h2008, 32'hB2B2_0002, 4'h3);
        snoop(32'h1000, 1);
        snoop(32'h1020, 2);
        snoop(32'h3000, 7);
        cyc(1, 0, 0, 32'h1000, 0, 0, 2, 0, 0, 0);
        chk("R5 weak or missing snoops harmless", {63'd0, evt_intf}, 64'd0);
        close(32'h1044, 32'hC3C3_0003, 4'hC, 1, 0, 0, 0);
        @(negedge clk);
        chk("R9 idle after commit", {62'd0, evt_active, evt_intf}, 64'd0);

        // R4 / R6: outranking snoop kills, R8 outcome
        enroll(32'h4000, 3);
        snoop(32'h4010, 5);
        chk("R4 kill sets flag", {63'd0, evt_intf}, 64'd1);
        store(32'h4000, 32'h44, 4'hF);
        chk("R6 flag sticky", {63'd0, evt_intf}, 64'd1);
        close(32'h4004, 32'h45, 4'hF, 0, 0, 0, 0);

        // R3: store outside the line set
        enroll(32'h5000, 1);
        store(32'h6000, 32'h66, 4'hF);
        chk("R3 stray store fails", {63'd0, evt_intf}, 64'd1);
        close(32'h5000, 32'h50, 4'hF, 0, 0, 0, 0);

        // R1 / R2: eight distinct lines plus repeats, then a ninth
        for (int i = 0; i < 8; i++) enroll(32'h8000 + i * 64, 2);
        enroll(32'h8004, 2);
        enroll(32'h81C8, 2);
        chk("R2 repeats take no slot", {63'd0, evt_intf}, 64'd0);
        enroll(32'h9000, 2);
        chk("R1 ninth line fails", {63'd0, evt_intf}, 64'd1);
        close(32'h8000, 32'h80, 4'hF, 0, 0, 0, 0);
        @(negedge clk);
        for (int i = 0; i < 8; i++) enroll(32'hA000 + i * 64, 2);
        chk("R9 fresh region has room", {63'd0, evt_intf}, 64'd0);
        close(32'hA1C0, 32'hA7, 4'h1, 1, 0, 0, 0);

        // R10: snoop and closing store in the same cycle
        enroll(32'hB000, 2);
        store(32'hB000, 32'hB0, 4'hF);
        close(32'hB008, 32'hB8, 4'hF, 0, 1, 32'hB020, 6);
        @(negedge clk);
        // R11: owner priority from the opening request; R10 control with an equal snoop
        enroll(32'hC000, 4);
        enroll(32'hC040, 0);
        snoop(32'hC040, 3);
        chk("R11 owner priority kept", {63'd0, evt_intf}, 64'd0);
        close(32'hC000, 32'hC0, 4'hF, 1, 1, 32'hC000, 4);
        @(negedge clk);

        // R12: buffer full leaves no room for the closing store
        enroll(32'hD000, 1);
        for (int i = 0; i < 8; i++) store(32'hD000 + i * 4, 32'hD0 + i, 4'hF);
        chk("R12 eight held stores accepted", {63'd0, evt_intf}, 64'd0);
        close(32'hD020, 32'hDD, 4'hF, 0, 0, 0, 0);
        @(negedge clk);
        enroll(32'hD000, 1);
        for (int i = 0; i < 7; i++) store(32'hD000 + i * 4, 32'hE0 + i, 4'h1 << (i % 4));
        close(32'hD03C, 32'hEF, 4'h8, 1, 0, 0, 0);
        @(negedge clk);

        // R3 corner: closing store with no region open fails
        close(32'hF000, 32'hF0, 4'hF, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        chk("R7 scoreboard drained", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule